// File: doc/BRIEF.md
# Dual-Phase Framed Serial Receiver

This block receives a synchronous serial stream, one bit per serial clock period, and builds words from it. The words are grouped into frames. A frame holds one or two phases, and each phase has its own word length and its own word count. The serial clock, frame-sync and data pins are brought into the system clock domain through a short synchronizer. The sampling edge of the serial clock and the active level of the frame sync are both selectable.

The receive path has three stages. Bits shift into a shift register. Each finished word moves to a buffer, and from the buffer it moves to a read register. A ready flag shows that the read register holds a word. Pulsing the read strobe consumes that word.

One interrupt output pulses on an event chosen by a mode field: a word becoming readable, the end of a frame, the start of a frame, or a frame sync that arrives too early. A separate pulse output reports that early sync. All settings come from one 32-bit control word.

Top module: `srx_rx`

## Requirements
- R1: The word-length code selects the bits per word: 000=8, 001=12, 010=16, 011=20, 100=24, 101=32. Codes 110 and 111 also give 32 bits.
- R2: Each word is received MSB first. In `rx_data` it is right-justified, and the bits above the word length are zero.
- R3: Phase 1 takes its word-length code from ctrl[7:5] and its word count from ctrl[14:8]. The count field holds the number of words minus one, so a phase holds 1 to 128 words.
- R4: When ctrl[31]=1, the frame carries a second phase after the first. Phase 2 takes its word-length code from ctrl[23:21] and its count field from ctrl[30:24]. When ctrl[31]=0, the frame ends after phase 1.
- R5: A frame starts on a sampling edge where the frame sync is active and was inactive at the previous sampling edge. That same edge carries the first data bit. Samples taken after a frame completes, and before the next frame start, produce no words.
- R6: With ctrl[0]=1, data and frame sync are sampled on the rising edge of `sclk`; with ctrl[0]=0, on the falling edge. With ctrl[1]=0 the frame sync is active high; with ctrl[1]=1 it is active low.
- R7: A finished word moves into the buffer. From there it moves to `rx_data` when `rx_ready` is low or `rd_stb` is high. The ready flag and the strobe behave as follows:
  - `rx_ready` goes high when a word is loaded and stays high until `rd_stb` is pulsed.
  - `rd_stb` clears `rx_ready`, unless a buffered word moves into `rx_data` in the same cycle.
  - `rx_data` changes only when a word is loaded.
  - Both outputs are zero after reset.
- R8: ctrl[3:2] selects the source of the one-cycle `rx_irq` pulse: 00 is a word loaded into `rx_data`, 01 is the end of a frame, 10 is a frame start, 11 is a sync error.
- R9: A frame start while a frame is still in progress pulses `rx_sync_err`. Reception then restarts at word 0 of phase 1, and that sample is the first bit of the new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl | input | 32 | Receive control word (fields as in R1 to R8) |
| sclk | input | 1 | Serial clock pin |
| sfs | input | 1 | Frame-sync pin |
| sdat | input | 1 | Serial data pin |
| rd_stb | input | 1 | Read strobe; consumes the word in `rx_data` |
| rx_data | output | 32 | Read register, right-justified word |
| rx_ready | output | 1 | Read register holds an unread word |
| rx_irq | output | 1 | Interrupt pulse, source chosen by ctrl[3:2] |
| rx_sync_err | output | 1 | Pulse on a frame start inside a frame |

## Verification
An internal fault shows at the ports in different ways, depending on which counter is wrong:
- A bit counter that is off by one shows within the first word: the value in `rx_data` is shifted, or it has stray high bits.
- A word counter or phase register that is wrong shows as a missing or extra word once the frame ends. It can also show as a phase-2 word that comes back at the phase-1 width.
- A busy state that is not cleared makes samples after the frame produce words.

The frame-end, frame-start and sync-error interrupt counts expose a wrong frame state one system cycle after the event. A read-register handshake fault shows as a lost or repeated word on the very next strobe.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 32;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int LEN_W  = 7;

  typedef enum logic [1:0] {
    IRQ_WORD   = 2'd0,
    IRQ_FEND   = 2'd1,
    IRQ_FSTART = 2'd2,
    IRQ_SERR   = 2'd3
  } irq_mode_e;

  typedef struct packed {
    logic [2:0]       wl;
    logic [LEN_W-1:0] len;
  } phase_cfg_t;

  // index of the last bit of a word for a word-length code
  function automatic logic [BIT_W-1:0] last_bit_idx(input logic [2:0] code);
    case (code)
      3'd0:    return BIT_W'(7);
      3'd1:    return BIT_W'(11);
      3'd2:    return BIT_W'(15);
      3'd3:    return BIT_W'(19);
      3'd4:    return BIT_W'(23);
      default: return BIT_W'(31);
    endcase
  endfunction

  function automatic phase_cfg_t cfg_phase1(input logic [31:0] c);
    phase_cfg_t p;
    p.wl  = c[7:5];
    p.len = c[14:8];
    return p;
  endfunction

  function automatic phase_cfg_t cfg_phase2(input logic [31:0] c);
    phase_cfg_t p;
    p.wl  = c[23:21];
    p.len = c[30:24];
    return p;
  endfunction

  // shift one bit in at the LSB; a new word starts from zero
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] prev,
                                                 input logic clr, input logic b);
    logic [DATA_W-1:0] base;
    base = clr ? '0 : prev;
    return {base[DATA_W-2:0], b};
  endfunction
endpackage

// File: rtl/srx_pin_sync.sv
module srx_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_rise,
  input  logic fs_inv,
  input  logic sclk,
  input  logic sfs,
  input  logic sdat,
  output logic samp,
  output logic fs_on,
  output logic bit_val
);
  logic [STAGES-1:0][2:0] stg;
  logic                   clk_q;
  logic [2:0]             last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg   <= '0;
      clk_q <= 1'b0;
    end else begin
      stg[0] <= {sclk, sfs, sdat};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      clk_q <= stg[STAGES-1][2];
    end
  end

  assign last    = stg[STAGES-1];
  assign samp    = edge_rise ? (last[2] & ~clk_q) : (~last[2] & clk_q);
  assign fs_on   = last[1] ^ fs_inv;
  assign bit_val = last[0];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp,
  input  logic       fs_on,
  input  logic       dual,
  input  phase_cfg_t cfg1,
  input  phase_cfg_t cfg2,
  output logic       take,
  output logic       first,
  output logic       wdone,
  output logic       fstart,
  output logic       fend,
  output logic       serr
);
  logic             busy, phase, fs_prev;
  logic [BIT_W-1:0] bit_cnt, e_bit;
  logic [LEN_W-1:0] word_cnt, e_word;
  logic             e_ph, lastw;
  phase_cfg_t       cur;

  always_comb begin
    fstart = samp & fs_on & ~fs_prev;
    take   = samp & (busy | fstart);
    e_ph   = fstart ? 1'b0 : phase;
    e_bit  = fstart ? '0 : bit_cnt;
    e_word = fstart ? '0 : word_cnt;
    cur    = e_ph ? cfg2 : cfg1;
    first  = (e_bit == '0);
    wdone  = take & (e_bit == last_bit_idx(cur.wl));
    lastw  = (e_word == cur.len);
    fend   = wdone & lastw & (e_ph | ~dual);
    serr   = fstart & busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase    <= 1'b0;
      fs_prev  <= 1'b0;
      bit_cnt  <= '0;
      word_cnt <= '0;
    end else begin
      if (samp) fs_prev <= fs_on;
      if (take) begin
        if (wdone) begin
          bit_cnt <= '0;
          if (lastw) begin
            word_cnt <= '0;
            busy     <= ~fend;
            phase    <= ~fend;
          end else begin
            word_cnt <= e_word + 1'b1;
            busy     <= 1'b1;
            phase    <= e_ph;
          end
        end else begin
          bit_cnt  <= e_bit + 1'b1;
          word_cnt <= e_word;
          busy     <= 1'b1;
          phase    <= e_ph;
        end
      end
    end
  end
endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic              bit_val,
  input  logic              wdone,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ready,
  output logic              move
);
  logic [DATA_W-1:0] shreg, buf_q, sh_nxt;
  logic              buf_v;

  assign sh_nxt = shift_in(shreg, first, bit_val);
  assign move   = buf_v & (~rd_ready | rd_stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      buf_q    <= '0;
      buf_v    <= 1'b0;
      rd_data  <= '0;
      rd_ready <= 1'b0;
    end else begin
      if (take)  shreg <= sh_nxt;
      if (wdone) buf_q <= sh_nxt;
      buf_v <= wdone | (buf_v & ~move);
      if (move) begin
        rd_data  <= buf_q;
        rd_ready <= 1'b1;
      end else if (rd_stb) begin
        rd_ready <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srx_rx.sv
module srx_rx
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ctrl,
  input  logic              sclk,
  input  logic              sfs,
  input  logic              sdat,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_irq,
  output logic              rx_sync_err
);
  // named internal events, also observed by the checker
  logic      samp, fs_on, bit_val;
  logic      take, first, wdone, fstart, fend, serr, move;
  irq_mode_e imode;

  assign imode = irq_mode_e'(ctrl[3:2]);

  srx_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .edge_rise(ctrl[0]), .fs_inv(ctrl[1]),
    .sclk(sclk), .sfs(sfs), .sdat(sdat),
    .samp(samp), .fs_on(fs_on), .bit_val(bit_val)
  );

  srx_framer u_frm (
    .clk(clk), .rst_n(rst_n), .samp(samp), .fs_on(fs_on), .dual(ctrl[31]),
    .cfg1(cfg_phase1(ctrl)), .cfg2(cfg_phase2(ctrl)),
    .take(take), .first(first), .wdone(wdone), .fstart(fstart),
    .fend(fend), .serr(serr)
  );

  srx_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .bit_val(bit_val),
    .wdone(wdone), .rd_stb(rd_stb),
    .rd_data(rx_data), .rd_ready(rx_ready), .move(move)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_irq      <= 1'b0;
      rx_sync_err <= 1'b0;
    end else begin
      rx_sync_err <= serr;
      case (imode)
        IRQ_WORD:   rx_irq <= move;
        IRQ_FEND:   rx_irq <= fend;
        IRQ_FSTART: rx_irq <= fstart;
        default:    rx_irq <= serr;
      endcase
    end
  end
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl,
  input logic        rd_stb,
  input logic [31:0] rx_data,
  input logic        rx_ready,
  input logic        rx_irq,
  input logic        rx_sync_err,
  input logic        fstart,
  input logic        fend,
  input logic        move
);
  // R8: word-ready mode pulses the interrupt after each load
  a_r8_word_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3:2] == 2'd0 && move) |=> rx_irq);

  // R8: frame-end mode interrupt only follows a frame end
  a_r8_fend_src: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && $past(ctrl[3:2]) == 2'd1) |-> $past(fend));

  // R9: sync error only follows a frame start
  a_r9_serr_src: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sync_err |-> $past(fstart));

  // R7: read strobe clears ready when nothing new moves in
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rx_ready && !move) |=> !rx_ready);

  // R7: read register holds its value between loads
  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !move |=> $stable(rx_data));

  // R5: a frame never starts and ends on the same sample
  a_r5_start_end_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fstart, fend}));
endmodule

bind srx_rx srx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .rd_stb(rd_stb), .rx_data(rx_data),
  .rx_ready(rx_ready), .rx_irq(rx_irq), .rx_sync_err(rx_sync_err),
  .fstart(fstart), .fend(fend), .move(move)
);

// File: tb/srx_rx_test.sv
`timescale 1ns/1ps
module srx_rx_test;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic        sclk = 1'b0, sfs = 1'b0, sdat = 1'b0;
  logic        auto_stb = 1'b0, man_stb = 1'b0, auto_rd = 1'b1;
  logic        rd_stb;
  logic [31:0] rx_data;
  logic        rx_ready, rx_irq, rx_sync_err;
  logic        cpol = 1'b1, fsinv = 1'b0;

  int errors = 0, checks = 0, nwords = 0, nirq = 0, nserr = 0;
  logic [31:0] words [0:255];
  bit done = 0;

  assign rd_stb = auto_stb | man_stb;

  srx_rx uut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .sclk(sclk), .sfs(sfs), .sdat(sdat),
    .rd_stb(rd_stb), .rx_data(rx_data), .rx_ready(rx_ready), .rx_irq(rx_irq),
    .rx_sync_err(rx_sync_err)
  );

  always #4 clk = ~clk;

  // monitor: reads words and counts pulses
  always @(negedge clk) begin
    if (rst_n && auto_rd && rx_ready && !auto_stb) begin
      if (nwords < 256) words[nwords] = rx_data;
      nwords++;
      auto_stb <= 1'b1;
    end else begin
      auto_stb <= 1'b0;
    end
    if (rst_n && rx_irq) nirq++;
    if (rst_n && rx_sync_err) nserr++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit dual, input int len2, input int wl2,
                                     input int len1, input int wl1, input int mode,
                                     input bit fs_low, input bit rise);
    return {dual, 7'(len2), 3'(wl2), 6'd0, 7'(len1), 3'(wl1), 1'b0, 2'(mode), fs_low, rise};
  endfunction

  task automatic set_cfg(input logic [31:0] c);
    ctrl  = c;
    cpol  = c[0];
    fsinv = c[1];
    sfs   = fsinv;
    sclk  = ~cpol;
    repeat (20) @(negedge clk);
    nwords = 0; nirq = 0; nserr = 0;
  endtask

  task automatic send_bit(input logic b, input logic fs_b);
    sclk = ~cpol;
    sfs  = fs_b ^ fsinv;
    sdat = b;
    repeat (HALF) @(negedge clk);
    sclk = cpol;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] v, input int n, input bit fs_first);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i], fs_first && (i == n - 1));
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R7 reset ready", {31'd0, rx_ready}, 32'd0);
    check("R7 reset data", rx_data, 32'd0);
    check("R8 reset irq", {31'd0, rx_irq}, 32'd0);
    check("R9 reset serr", {31'd0, rx_sync_err}, 32'd0);
  endtask

  task automatic t_single8();
    set_cfg(mk(0, 0, 0, 1, 0, 0, 0, 1));
    send_word(32'hA5, 8, 1);
    send_word(32'h3C, 8, 0);
    settle();
    check("R3 two words", nwords, 2);
    check("R2 word0", words[0], 32'hA5);
    check("R2 word1", words[1], 32'h3C);
    check("R8 word irq count", nirq, 2);
  endtask

  task automatic t_lengths();
    int nb [8] = '{8, 12, 16, 20, 24, 32, 32, 32};
    logic [31:0] v = 32'hC3A5_96E7;
    for (int code = 0; code < 8; code++) begin
      logic [31:0] exp;
      set_cfg(mk(0, 0, 0, 0, code, 0, 0, 1));
      send_word(v, nb[code], 1);
      settle();
      exp = (nb[code] == 32) ? v : (v & ((32'd1 << nb[code]) - 1));
      check($sformatf("R1 code %0d count", code), nwords, 1);
      check($sformatf("R1 code %0d value", code), words[0], exp);
    end
  endtask

  task automatic t_dual();
    set_cfg(mk(1, 0, 2, 1, 0, 1, 0, 1));
    send_word(32'h81, 8, 1);
    send_word(32'h7E, 8, 0);
    send_word(32'hBEEF, 16, 0);
    settle();
    check("R4 dual count", nwords, 3);
    check("R4 dual w0", words[0], 32'h81);
    check("R4 dual w1", words[1], 32'h7E);
    check("R4 phase2 16-bit", words[2], 32'hBEEF);
    check("R8 frame-end irq", nirq, 1);
    send_word(32'hFF, 8, 0);
    send_word(32'hFFFF, 16, 0);
    settle();
    check("R5 no fs ignored", nwords, 3);
  endtask

  task automatic t_pol();
    set_cfg(mk(0, 0, 0, 0, 1, 2, 1, 0));
    send_word(32'h5A3, 12, 1);
    settle();
    check("R6 falling/active-low count", nwords, 1);
    check("R6 falling/active-low value", words[0], 32'h5A3);
    check("R8 frame-start irq", nirq, 1);
  endtask

  task automatic t_serr();
    set_cfg(mk(1, 0, 2, 0, 0, 3, 0, 1));
    send_word(32'h11, 8, 1);
    send_word(32'h22, 8, 1);
    send_word(32'h3344, 16, 0);
    settle();
    check("R9 word count", nwords, 3);
    check("R9 w0", words[0], 32'h11);
    check("R9 restart phase1 8-bit", words[1], 32'h22);
    check("R9 then phase2 16-bit", words[2], 32'h3344);
    check("R9 serr pulses", nserr, 1);
    check("R8 serr irq", nirq, 1);
  endtask

  task automatic t_hold();
    auto_rd = 1'b0;
    set_cfg(mk(0, 0, 0, 1, 0, 0, 0, 1));
    send_word(32'h12, 8, 1);
    send_word(32'h34, 8, 0);
    settle();
    check("R7 ready held", {31'd0, rx_ready}, 32'd1);
    check("R7 first word kept", rx_data, 32'h12);
    man_stb = 1'b1; @(negedge clk); man_stb = 1'b0; @(negedge clk);
    check("R7 buffered word moves", rx_data, 32'h34);
    check("R7 ready after move", {31'd0, rx_ready}, 32'd1);
    man_stb = 1'b1; @(negedge clk); man_stb = 1'b0; @(negedge clk);
    check("R7 ready cleared", {31'd0, rx_ready}, 32'd0);
    check("R7 data unchanged", rx_data, 32'h34);
    auto_rd = 1'b1;
  endtask

  task automatic t_max();
    int bad = 0;
    set_cfg(mk(0, 0, 0, 127, 0, 0, 0, 1));
    for (int i = 0; i < 128; i++) send_word(32'(i), 8, i == 0);
    send_word(32'hEE, 8, 0);
    settle();
    check("R3 128 words", nwords, 128);
    for (int i = 0; i < 128; i++) if (words[i] !== 32'(i)) bad++;
    check("R3 128 values", bad, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_single8();
    t_lengths();
    t_dual();
    t_pol();
    t_serr();
    t_hold();
    t_max();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule